// File: doc/BRIEF.md
# Configuration Space Read Requester

This block sits on the user side of a link endpoint. It turns local read commands into reads of the endpoint's configuration space over a narrow sideband port. Local logic offers a 10-bit doubleword address with a valid/ready handshake. The block then drives a one-cycle, active-low read strobe together with the address. It waits for the active-low done indication and returns the 32-bit word as a one-cycle response that carries the address.

The sideband port is only usable some time after the link comes up. The block therefore keeps its command side closed until the link-up indication has been held for a settle period. A read that gets no done within the answer window is re-issued automatically, up to a retry limit. After the limit, the read is reported as an error together with its address. If the link drops while a read is waiting, that read is abandoned with an error, and the settle period starts over when the link returns. Only one read is ever in flight.

Top module: `cfg_rd_requester`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises with the link down, `cfg_rd_n` is 1, `req_ready` is 0 and `rsp_valid` is 0.
- R2: `req_ready` stays 0 until `link_up_n` has been sampled low on SETTLE_CYC (default 20) consecutive rising edges. It is first 1 in the cycle after the last of those edges, and no strobe appears before that point.
- R3: A command is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `cfg_rd_n` is then low for exactly one cycle, the cycle after that edge. `cfg_addr` equals the accepted address from then until the next acceptance.
- R4: If `cfg_done_n` is sampled low on the edge that ends any of the TIMEOUT_CYC (default 10) cycles that begin with the strobe cycle, `rsp_valid` pulses for one cycle right after that edge. In that pulse `rsp_err` is 0, `rsp_data` holds the `cfg_rdata` sampled on that edge, and `rsp_addr` holds the command address.
- R5: If no done arrives in the window, the same address is strobed again. The new strobe comes exactly TIMEOUT_CYC cycles after the previous one.
- R6: A read is strobed at most 1+MAX_RETRY times (default 4). If the last window also expires, `rsp_valid` pulses TIMEOUT_CYC cycles after the last strobe, with `rsp_err`=1 and `rsp_data`=0, and no further strobe follows.
- R7: If `link_up_n` is sampled high while a read waits, the next cycle carries `rsp_valid` with `rsp_err`=1 and no further strobe follows. `req_ready` then stays 0 until the link has again been up for SETTLE_CYC edges.
- R8: `req_ready` is 0 from the cycle after an acceptance until the cycle in which that read's response is presented.
- R9: `cfg_done_n` going low while no read is waiting is ignored and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transaction clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| link_up_n | input | 1 | Link-up indication, low when up |
| req_valid | input | 1 | Read command offered |
| req_addr | input | ADDR_W (10) | Doubleword address of the command |
| req_ready | output | 1 | Command can be accepted |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Response is a failure (retries used up or link lost) |
| rsp_addr | output | ADDR_W (10) | Address the response belongs to |
| rsp_data | output | DATA_W (32) | Read data, zero on error |
| cfg_rd_n | output | 1 | Active-low single-cycle read strobe |
| cfg_addr | output | ADDR_W (10) | Sideband doubleword address |
| cfg_done_n | input | 1 | Active-low done, qualifies cfg_rdata |
| cfg_rdata | input | DATA_W (32) | Sideband read data |

## Verification
The bench builds the block with its defaults: a 20-edge settle, a 10-cycle window and 3 retries. The exact settle boundary, the done accepted in the strobe cycle and in the last window cycle, and the 10-cycle strobe spacing are therefore all checked at the sideband's real numbers. Three retries keep a fully unanswered read at four strobes and about forty cycles. This leaves room to check exhaustion next to link loss in the middle of a read, the re-run settle period, and a stray done in idle.

// File: rtl/cfg_rd_pkg.sv
package cfg_rd_pkg;
  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_WAIT = 1'b1} rd_state_e;

  // attempts made so far (after the first) against the retry cap
  function automatic logic retries_spent(input int unsigned used, input int unsigned cap);
    return used >= cap;
  endfunction

  // counter step that stops at its ceiling
  function automatic int unsigned step_sat(input int unsigned cur, input int unsigned ceil);
    return (cur >= ceil) ? ceil : cur + 1;
  endfunction
endpackage

// File: rtl/cfg_link_gate.sv
module cfg_link_gate #(
  parameter int unsigned SETTLE_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_up_n,
  output logic link_ok
);
  import cfg_rd_pkg::*;
  localparam int unsigned CW = $clog2(SETTLE_CYC + 1);

  logic [CW-1:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || link_up_n) hold_cnt <= '0;
    else                     hold_cnt <= CW'(step_sat(int'(hold_cnt), SETTLE_CYC));
  end

  assign link_ok = !link_up_n && (hold_cnt == CW'(SETTLE_CYC));

  // R7: a dropped link closes the gate on the following cycle
  a_r7_gate_clears: assert property (@(posedge clk) disable iff (!rst_n)
    link_up_n |=> !link_ok);
  // R2: once open, the gate stays open while the link holds
  a_r2_gate_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (link_ok && !link_up_n) |=> (link_ok || link_up_n));
endmodule

// File: rtl/cfg_rd_timer.sv
module cfg_rd_timer #(
  parameter int unsigned TIMEOUT_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expired
);
  localparam int unsigned TW = (TIMEOUT_CYC < 2) ? 1 : $clog2(TIMEOUT_CYC);

  logic [TW-1:0] win_cnt;

  assign expired = (win_cnt == TW'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || restart)   win_cnt <= '0;
    else if (run && !expired) win_cnt <= win_cnt + 1'b1;
  end

  // R5: the window only advances while a read is waiting
  a_r5_window_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(win_cnt));
endmodule

// File: rtl/cfg_rd_requester.sv
module cfg_rd_requester #(
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SETTLE_CYC  = 20,
  parameter int unsigned TIMEOUT_CYC = 10,
  parameter int unsigned MAX_RETRY   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_up_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [DATA_W-1:0] rsp_data,
  output logic              cfg_rd_n,
  output logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_done_n,
  input  logic [DATA_W-1:0] cfg_rdata
);
  import cfg_rd_pkg::*;
  localparam int unsigned RW = $clog2(MAX_RETRY + 1) < 1 ? 1 : $clog2(MAX_RETRY + 1);

  rd_state_e         state;
  logic [ADDR_W-1:0] addr_q;
  logic [RW-1:0]     tries_q;
  logic              rd_n_q, rsp_valid_q, rsp_err_q;
  logic [DATA_W-1:0] rsp_data_q;

  // named internal events
  logic link_ok_w, win_expired_w;
  logic ev_issue, ev_done, ev_expire, ev_retry, ev_giveup, ev_abort, ev_finish;

  cfg_link_gate #(.SETTLE_CYC(SETTLE_CYC)) u_gate (
    .clk(clk), .rst_n(rst_n), .link_up_n(link_up_n), .link_ok(link_ok_w));

  cfg_rd_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(ev_issue || ev_retry),
    .run(state == ST_WAIT), .expired(win_expired_w));

  assign req_ready = (state == ST_IDLE) && link_ok_w;
  assign ev_issue  = req_valid && req_ready;
  assign ev_abort  = (state == ST_WAIT) && link_up_n;
  assign ev_done   = (state == ST_WAIT) && !link_up_n && !cfg_done_n;
  assign ev_expire = (state == ST_WAIT) && !link_up_n && cfg_done_n && win_expired_w;
  assign ev_giveup = ev_expire && retries_spent(int'(tries_q), MAX_RETRY);
  assign ev_retry  = ev_expire && !ev_giveup;
  assign ev_finish = ev_done || ev_giveup || ev_abort;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      addr_q      <= '0;
      tries_q     <= '0;
      rd_n_q      <= 1'b1;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rd_n_q      <= !(ev_issue || ev_retry);
      rsp_valid_q <= ev_finish;
      if (ev_finish) begin
        rsp_err_q  <= !ev_done;
        rsp_data_q <= ev_done ? cfg_rdata : '0;
      end
      if (ev_issue) begin
        state   <= ST_WAIT;
        addr_q  <= req_addr;
        tries_q <= '0;
      end else if (ev_finish) begin
        state <= ST_IDLE;
      end else if (ev_retry) begin
        tries_q <= tries_q + 1'b1;
      end
    end
  end

  assign cfg_rd_n  = rd_n_q;
  assign cfg_addr  = addr_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_addr  = addr_q;
  assign rsp_data  = rsp_data_q;

  // R3: the strobe never lasts two cycles
  a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rd_n |=> cfg_rd_n);
  // R2: a strobe only follows a cycle in which the settled gate was open
  a_r2_strobe_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rd_n |-> $past(link_ok_w));
  // R8: an accepted command closes the command side
  a_r8_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R4: a good response needs a done on the previous edge
  a_r4_ok_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err) |-> $past(!cfg_done_n));
  // R7: link loss while waiting yields an error response
  a_r7_abort_reports: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_WAIT) && link_up_n) |=> (rsp_valid && rsp_err));
  // R3: the sideband address is held while a read waits
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_WAIT) && $past(state == ST_WAIT)) |-> $stable(cfg_addr));
endmodule

// File: tb/tb_cfg_rd_requester.sv
module tb_cfg_rd_requester;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rst_n, link_up_n, req_valid, req_ready, rsp_valid, rsp_err, cfg_rd_n;
  logic cfg_done_n;
  logic [ADDR_W-1:0] req_addr, rsp_addr, cfg_addr;
  logic [DATA_W-1:0] rsp_data, cfg_rdata;

  always #2.5 clk = ~clk;

  cfg_rd_requester dut (
    .clk(clk), .rst_n(rst_n), .link_up_n(link_up_n), .req_valid(req_valid),
    .req_addr(req_addr), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
    .cfg_rd_n(cfg_rd_n), .cfg_addr(cfg_addr), .cfg_done_n(cfg_done_n),
    .cfg_rdata(cfg_rdata));

  typedef struct {
    int              kind;   // 0 good, 1 retries spent, 2 link lost
    logic [ADDR_W-1:0] addr;
  } exp_t;
  exp_t exp_q[$];

  int n_checks = 0, n_fail = 0, cyc = 0;
  int strobes = 0, last_strobe_cyc = 0, strobe_gap = 0, done_cyc = 0;
  int drop = 0, delay = 0, countdown = 0, rsp_count = 0;
  bit spurious = 0, prev_strobe = 0, finished = 0;
  logic [ADDR_W-1:0] cur_addr = '0;

  function automatic logic [DATA_W-1:0] mk_data(input logic [ADDR_W-1:0] a);
    return 32'h5A3C_96E1 ^ {a, a, a, 2'b01};
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // sideband responder
  always @(negedge clk) begin
    if (cfg_done_n == 1'b0) cfg_done_n = 1'b1;
    if (spurious) begin
      cfg_done_n = 1'b0; cfg_rdata = 32'hDEAD_BEEF; spurious = 0;
    end
    if (countdown > 0) begin
      countdown--;
      if (countdown == 0) begin
        cfg_done_n = 1'b0; cfg_rdata = mk_data(cfg_addr); done_cyc = cyc;
      end
    end
    if (rst_n && !cfg_rd_n) begin
      check(!prev_strobe, "R3 strobe width", 2, 1);
      check(cfg_addr == cur_addr, "R3 cfg_addr", cfg_addr, cur_addr);
      strobe_gap = cyc - last_strobe_cyc;
      last_strobe_cyc = cyc;
      strobes++;
      if (drop > 0) drop--;
      else if (delay == 0) begin
        cfg_done_n = 1'b0; cfg_rdata = mk_data(cfg_addr); done_cyc = cyc;
      end else countdown = delay;
    end
    prev_strobe = rst_n && !cfg_rd_n;
  end

  // response monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      rsp_count++;
      check(exp_q.size() != 0, "R9 unexpected response", rsp_addr, 0);
      if (exp_q.size() != 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(rsp_err == (e.kind != 0), "R4/R6/R7 rsp_err", rsp_err, e.kind != 0);
        check(rsp_addr == e.addr, "R4 rsp_addr", rsp_addr, e.addr);
        if (e.kind == 0) begin
          check(rsp_data == mk_data(e.addr), "R4 rsp_data", rsp_data, mk_data(e.addr));
          check(cyc - done_cyc == 1, "R4 latency", cyc - done_cyc, 1);
        end else begin
          check(rsp_data == '0, "R6 error data", rsp_data, 0);
        end
        if (e.kind == 1)
          check(cyc - last_strobe_cyc == 10, "R6 error timing", cyc - last_strobe_cyc, 10);
      end
    end
  end

  task automatic settle_link();
    link_up_n = 1'b0;
    repeat (19) tick();
    check(!req_ready, "R2 ready before settle", req_ready, 0);
    tick();
    check(req_ready, "R2 ready at settle", req_ready, 1);
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, input int drp, input int dly, input int kind);
    int s0, att;
    exp_t e;
    drop = drp; delay = dly; cur_addr = a;
    e.kind = kind; e.addr = a;
    exp_q.push_back(e);
    s0 = strobes;
    req_valid = 1'b1; req_addr = a;
    while (!req_ready) tick();
    tick();
    req_valid = 1'b0;
    check(!req_ready, "R8 ready low while waiting", req_ready, 0);
    while (exp_q.size() != 0) tick();
    att = (drp > 3) ? 4 : drp + 1;
    check(strobes - s0 == att, "R5/R6 strobe count", strobes - s0, att);
    if (drp == 1) check(strobe_gap == 10, "R5 retry spacing", strobe_gap, 10);
    check(req_ready, "R8 ready after response", req_ready, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int s0, r0;
    rst_n = 0; link_up_n = 1; req_valid = 0; req_addr = '0;
    cfg_done_n = 1; cfg_rdata = '0;
    repeat (3) tick();
    check(cfg_rd_n, "R1 strobe idle in reset", cfg_rd_n, 1);
    check(!req_ready, "R1 ready in reset", req_ready, 0);
    check(!rsp_valid, "R1 rsp in reset", rsp_valid, 0);
    rst_n = 1;
    tick();
    check(!req_ready && cfg_rd_n, "R1 after reset, link down", {req_ready, cfg_rd_n}, 1);

    // R9: done while idle
    r0 = rsp_count; spurious = 1;
    repeat (3) tick();
    check(rsp_count == r0, "R9 stray done ignored", rsp_count, r0);

    settle_link();
    do_read(10'h000, 0, 0, 0);   // R4 done in strobe cycle
    do_read(10'h3FF, 0, 9, 0);   // R4 done in last window cycle
    do_read(10'h155, 0, 4, 0);
    do_read(10'h2AA, 1, 0, 0);   // R5 one retry
    do_read(10'h0F0, 3, 2, 0);   // R5 last allowed attempt answers
    do_read(10'h123, 4, 0, 1);   // R6 retries spent
    s0 = strobes;
    repeat (30) tick();
    check(strobes == s0, "R6 no strobe after give-up", strobes - s0, 0);

    // R7: link loss mid-read
    begin
      exp_t e;
      e.kind = 2; e.addr = 10'h0AB;
      exp_q.push_back(e);
      drop = 100; cur_addr = 10'h0AB;
      req_valid = 1; req_addr = 10'h0AB;
      while (!req_ready) tick();
      tick();
      req_valid = 0;
      repeat (2) tick();
      link_up_n = 1;
      s0 = strobes;
      while (exp_q.size() != 0) tick();
      repeat (15) tick();
      check(strobes == s0, "R7 no strobe after abort", strobes - s0, 0);
      check(!req_ready, "R7 ready low while link down", req_ready, 0);
    end

    // R7/R2: settle restarts, early request held off
    begin
      exp_t e;
      e.kind = 0; e.addr = 10'h301;
      exp_q.push_back(e);
      drop = 0; delay = 3; cur_addr = 10'h301;
      req_valid = 1; req_addr = 10'h301;
      s0 = strobes;
      link_up_n = 0;
      repeat (19) tick();
      check(!req_ready, "R7 settle restarted", req_ready, 0);
      tick();
      check(req_ready && strobes == s0, "R2 no early strobe", strobes - s0, 0);
      tick();
      req_valid = 0;
      check(strobes - s0 == 1, "R2 strobe after settle", strobes - s0, 1);
      while (exp_q.size() != 0) tick();
    end

    repeat (3) tick();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule